// File: doc/BRIEF.md
# Display Memory Pattern Fill Engine

This block clears or tiles a 102-column by 8-page display memory in response to a single instruction. It stands in for the 816 separate write instructions a host would otherwise need. The instruction decoder raises a command strobe together with a pattern select. The host interface then gives a one-cycle pulse at the final active edge of that instruction. Starting from that pulse, the engine drives the memory write port once per clock until every location holds the chosen pattern.

There are two patterns. The blank pattern writes zero everywhere. The checkerboard pattern writes alternating bytes from column to column, so neighbouring pixels differ both horizontally and vertically. While the engine owns the write port it holds a busy flag, and the decoder uses that flag to turn away further instructions. When the display is powered down, the fill instruction is dropped.

Top module: `pfill_engine`

## Requirements
- R1: After reset, `busy`, `wr_en` and `done` are all low.
- R2: A fill command (`cmd_valid` high) is accepted only while `pwr_down` is 0 and `busy` is low. `busy` is high in the cycle after the accepting edge. While the engine waits for the edge pulse, `busy` stays high and `wr_en` stays low.
- R3: A fill command that arrives while `pwr_down` is 1 is dropped: `busy` stays low and no write occurs.
- R4: Suppose `last_edge` is sampled high at edge k, either with a command pending or at the same edge that accepts the command. Then `wr_en` is low after edge k and high after edge k+1, so the memory captures the first write at edge k+2.
- R5: A fill produces exactly 816 writes on consecutive clocks, with no gap.
- R6: Addresses run column first, with `wr_col` going from 0 to 101 and then `wr_page` stepping from 0 to 7. The first write goes to column 0, page 0.
- R7: Pattern select 0 (blank) writes 8'h00 to every location.
- R8: Pattern select 1 (checkerboard) writes 8'h55 to even columns and 8'hAA to odd columns, on every page.
- R9: A command that arrives while `busy` is high is ignored. It neither changes the pattern of the fill in progress nor starts a new fill afterwards.
- R10: `busy` falls in the cycle after the final write. `done` is high for exactly that one cycle.
- R11: A `last_edge` pulse with no command pending causes no write and leaves `busy` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Fill command strobe from the decoder |
| cmd_pat | input | 1 | Pattern select: 0 blank, 1 checkerboard |
| pwr_down | input | 1 | Display powered down; fill commands are dropped |
| last_edge | input | 1 | One-cycle pulse at the last active interface edge |
| wr_col | output | 7 | Write address, column |
| wr_page | output | 3 | Write address, page |
| wr_data | output | 8 | Write data |
| wr_en | output | 1 | Memory write enable |
| busy | output | 1 | Engine active; decoder rejects instructions |
| done | output | 1 | One-cycle pulse when the fill completes |

## Verification
The hardest case to reach from the ports is a second command arriving in the middle of a long fill. A fault there would only show up if it altered the bytes already being written, or if it triggered a hidden follow-on fill. The stimulus runs a blank fill over a memory model preloaded with a non-zero sentinel. Halfway through, at write 400, it strobes a checkerboard command. It then checks that all 816 locations read back zero, that the write count is exactly 816, and that `busy` stays low for several cycles after `done`. The start latency is also tested in two ways: once with the edge pulse arriving well after the command, and once with both in the same cycle.

// File: rtl/pfill_pkg.sv
package pfill_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_WAIT  = 2'd2,
        ST_FILL  = 2'd3
    } fill_state_e;

    typedef enum logic {
        PAT_BLANK = 1'b0,
        PAT_CHECK = 1'b1
    } fill_pat_e;

    typedef struct packed {
        fill_state_e state;
        fill_pat_e   pat;
        logic        done;
    } ctrl_regs_t;

endpackage

// File: rtl/pfill_addr_gen.sv
module pfill_addr_gen #(
    parameter int NUM_COLS  = 102,
    parameter int NUM_PAGES = 8,
    localparam int COL_W    = $clog2(NUM_COLS),
    localparam int PAGE_W   = $clog2(NUM_PAGES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    output logic [COL_W-1:0]  col,
    output logic [PAGE_W-1:0] page,
    output logic              last
);

    localparam logic [COL_W-1:0]  COL_MAX  = COL_W'(NUM_COLS - 1);
    localparam logic [PAGE_W-1:0] PAGE_MAX = PAGE_W'(NUM_PAGES - 1);

    typedef struct packed {
        logic [COL_W-1:0]  col;
        logic [PAGE_W-1:0] page;
    } addr_regs_t;

    addr_regs_t a_d, a_q;

    always_comb begin
        a_d = a_q;
        if (!step) begin
            a_d = '0;
        end else if (a_q.col == COL_MAX) begin
            a_d.col  = '0;
            a_d.page = (a_q.page == PAGE_MAX) ? '0 : a_q.page + 1'b1;
        end else begin
            a_d.col = a_q.col + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) a_q <= '0;
        else        a_q <= a_d;
    end

    assign col  = a_q.col;
    assign page = a_q.page;
    assign last = (a_q.col == COL_MAX) && (a_q.page == PAGE_MAX);

    // R6
    col_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_q.col <= COL_MAX) && (a_q.page <= PAGE_MAX));

    // R6
    col_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && a_q.col != COL_MAX) |=> (a_q.col == COL_W'($past(a_q.col) + 1'b1))
                                          && $stable(a_q.page));

    // R6
    page_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && a_q.col == COL_MAX && a_q.page != PAGE_MAX) |=>
            (a_q.col == '0) && (a_q.page == PAGE_W'($past(a_q.page) + 1'b1)));

endmodule

// File: rtl/pfill_pattern.sv
module pfill_pattern
    import pfill_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  fill_pat_e          pat,
    input  logic               col_odd,
    output logic [DATA_W-1:0]  data
);

    localparam logic [DATA_W-1:0] EVEN_WORD = {(DATA_W / 2){2'b01}};
    localparam logic [DATA_W-1:0] ODD_WORD  = ~EVEN_WORD;

    always_comb begin
        if (pat == PAT_CHECK) data = col_odd ? ODD_WORD : EVEN_WORD;
        else                  data = '0;
    end

endmodule

// File: rtl/pfill_ctrl.sv
module pfill_ctrl
    import pfill_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cmd_valid,
    input  logic      cmd_pat,
    input  logic      pwr_down,
    input  logic      last_edge,
    input  logic      fill_last,
    output logic      fill_active,
    output logic      busy,
    output logic      done,
    output fill_pat_e pat
);

    ctrl_regs_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (cmd_valid && !pwr_down) begin
                    r_d.pat   = fill_pat_e'(cmd_pat);
                    r_d.state = last_edge ? ST_WAIT : ST_ARMED;
                end
            end
            ST_ARMED: begin
                if (last_edge) r_d.state = ST_WAIT;
            end
            ST_WAIT: begin
                r_d.state = ST_FILL;
            end
            ST_FILL: begin
                if (fill_last) begin
                    r_d.state = ST_IDLE;
                    r_d.done  = 1'b1;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{state: ST_IDLE, pat: PAT_BLANK, done: 1'b0};
        else        r_q <= r_d;
    end

    assign fill_active = (r_q.state == ST_FILL);
    assign busy        = (r_q.state != ST_IDLE);
    assign done        = r_q.done;
    assign pat         = r_q.pat;

    // R3
    pd_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_IDLE && cmd_valid && pwr_down) |=> !busy);

    // R4
    start_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fill_active) |-> ($past(r_q.state) == ST_WAIT));

    // R9
    pat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_valid) |=> $stable(r_q.pat));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(fill_active)));

    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: rtl/pfill_engine.sv
module pfill_engine
    import pfill_pkg::*;
#(
    parameter int NUM_COLS  = 102,
    parameter int NUM_PAGES = 8,
    parameter int DATA_W    = 8,
    localparam int COL_W    = $clog2(NUM_COLS),
    localparam int PAGE_W   = $clog2(NUM_PAGES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_pat,
    input  logic              pwr_down,
    input  logic              last_edge,
    output logic [COL_W-1:0]  wr_col,
    output logic [PAGE_W-1:0] wr_page,
    output logic [DATA_W-1:0] wr_data,
    output logic              wr_en,
    output logic              busy,
    output logic              done
);

    logic      fill_active;
    logic      fill_last;
    fill_pat_e pat;

    pfill_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid   (cmd_valid),
        .cmd_pat     (cmd_pat),
        .pwr_down    (pwr_down),
        .last_edge   (last_edge),
        .fill_last   (fill_last),
        .fill_active (fill_active),
        .busy        (busy),
        .done        (done),
        .pat         (pat)
    );

    pfill_addr_gen #(
        .NUM_COLS  (NUM_COLS),
        .NUM_PAGES (NUM_PAGES)
    ) u_addr (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (fill_active),
        .col   (wr_col),
        .page  (wr_page),
        .last  (fill_last)
    );

    pfill_pattern #(
        .DATA_W (DATA_W)
    ) u_pat (
        .pat     (pat),
        .col_odd (wr_col[0]),
        .data    (wr_data)
    );

    assign wr_en = fill_active;

    // R5
    no_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !fill_last) |=> wr_en);

    // R6
    first_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_en) |-> (wr_col == '0 && wr_page == '0));

    // R8
    check_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && pat == PAT_CHECK && wr_col != '0) |-> (wr_data == ~$past(wr_data)));

endmodule

// File: tb/pfill_engine_test.sv
module pfill_engine_test;

    localparam int NC = 102;
    localparam int NP = 8;
    localparam int TOTAL = NC * NP;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic       cmd_pat = 1'b0;
    logic       pwr_down = 1'b0;
    logic       last_edge = 1'b0;
    logic [6:0] wr_col;
    logic [2:0] wr_page;
    logic [7:0] wr_data;
    logic       wr_en;
    logic       busy;
    logic       done;

    logic [7:0] mem [NP][NC];
    int widx = 0;
    int order_err = 0;
    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    pfill_engine uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_pat   (cmd_pat),
        .pwr_down  (pwr_down),
        .last_edge (last_edge),
        .wr_col    (wr_col),
        .wr_page   (wr_page),
        .wr_data   (wr_data),
        .wr_en     (wr_en),
        .busy      (busy),
        .done      (done)
    );

    always @(posedge clk) begin
        if (rst_n && wr_en) begin
            if (int'(wr_col) != widx % NC || int'(wr_page) != widx / NC) order_err++;
            if (wr_col < NC && wr_page < NP) mem[wr_page][wr_col] = wr_data;
            widx++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic prefill();
        for (int p = 0; p < NP; p++)
            for (int c = 0; c < NC; c++)
                mem[p][c] = 8'hC3;
        widx = 0;
        order_err = 0;
    endtask

    task automatic verify_mem(input bit pat, input string req);
        int bad = 0;
        int first_act = 0;
        int first_exp = 0;
        for (int p = 0; p < NP; p++)
            for (int c = 0; c < NC; c++) begin
                logic [7:0] e;
                e = pat ? ((c % 2 == 1) ? 8'hAA : 8'h55) : 8'h00;
                if (mem[p][c] !== e) begin
                    if (bad == 0) begin
                        first_act = int'(mem[p][c]);
                        first_exp = int'(e);
                    end
                    bad++;
                end
            end
        chk(bad == 0, req, first_act, first_exp);
    endtask

    task automatic wait_end(input bit inject, input bit pat, output int n, output int gap);
        n = 1;
        gap = 0;
        forever begin
            @(negedge clk);
            if (cmd_valid) cmd_valid = 1'b0;
            if (!busy) break;
            if (wr_en) n++;
            else gap++;
            if (inject && n == 400) begin
                cmd_valid = 1'b1;
                cmd_pat   = ~pat;
            end
        end
    endtask

    task automatic test_reset();
        chk(busy == 1'b0, "R1 busy", int'(busy), 0);
        chk(wr_en == 1'b0, "R1 wr_en", int'(wr_en), 0);
        chk(done == 1'b0, "R1 done", int'(done), 0);
    endtask

    task automatic run_fill(input bit pat, input bit inject);
        int n;
        int gap;
        prefill();
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_pat   = pat;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(busy == 1'b1, "R2 busy after accept", int'(busy), 1);
        repeat (3) @(negedge clk);
        chk(busy && !wr_en, "R2 armed waits", int'(wr_en), 0);
        last_edge = 1'b1;
        @(negedge clk);
        last_edge = 1'b0;
        chk(wr_en == 1'b0, "R4 no write yet", int'(wr_en), 0);
        @(negedge clk);
        chk(wr_en == 1'b1, "R4 write starts", int'(wr_en), 1);
        wait_end(inject, pat, n, gap);
        chk(n == TOTAL && gap == 0, "R5 contiguous writes", n, TOTAL);
        chk(widx == TOTAL, "R5 write count", widx, TOTAL);
        chk(order_err == 0, "R6 address order", order_err, 0);
        chk(done == 1'b1 && wr_en == 1'b0, "R10 done with busy low", int'(done), 1);
        @(negedge clk);
        chk(done == 1'b0, "R10 done single cycle", int'(done), 0);
        if (inject) begin
            repeat (4) @(negedge clk);
            chk(busy == 1'b0 && widx == TOTAL, "R9 rejected cmd not queued", widx, TOTAL);
            verify_mem(pat, "R9 pattern unchanged");
        end else begin
            verify_mem(pat, pat ? "R8 checkerboard" : "R7 blank");
        end
    endtask

    task automatic test_power_down();
        prefill();
        pwr_down = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_pat   = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        last_edge = 1'b1;
        @(negedge clk);
        last_edge = 1'b0;
        chk(busy == 1'b0, "R3 busy stays low", int'(busy), 0);
        repeat (4) @(negedge clk);
        chk(widx == 0, "R3 no writes", widx, 0);
        pwr_down = 1'b0;
    endtask

    task automatic test_stray_edge();
        prefill();
        @(negedge clk);
        last_edge = 1'b1;
        @(negedge clk);
        last_edge = 1'b0;
        repeat (4) @(negedge clk);
        chk(busy == 1'b0 && widx == 0, "R11 stray pulse", widx, 0);
    endtask

    task automatic test_same_cycle();
        int n;
        int gap;
        prefill();
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_pat   = 1'b1;
        last_edge = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        last_edge = 1'b0;
        chk(busy && !wr_en, "R4 same-cycle wait", int'(wr_en), 0);
        @(negedge clk);
        chk(wr_en == 1'b1, "R4 same-cycle start", int'(wr_en), 1);
        wait_end(1'b0, 1'b1, n, gap);
        chk(n == TOTAL && gap == 0, "R5 same-cycle count", n, TOTAL);
        @(negedge clk);
        verify_mem(1'b1, "R8 same-cycle checkerboard");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        run_fill(1'b0, 1'b0);
        run_fill(1'b1, 1'b0);
        test_power_down();
        test_stray_edge();
        run_fill(1'b0, 1'b1);
        test_same_cycle();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule